// File: doc/BRIEF.md
# System Tick Down Counter

A periodic down-counter for operating-system time slicing and simple interval timing. Software loads a period into a reload register and turns the counter on. The counter then decrements on every selected count step. It steps either on every core clock or on each cycle of an external reference enable. When it passes from 1 to 0 it sets a sticky flag and can raise a one-cycle tick interrupt request. On the following step it reloads, so the period in steps is the reload value plus one.

Four word registers sit behind a plain synchronous read/write port:

- 0x0: control/status.
- 0x4: reload.
- 0x8: current value.
- 0xC: a read-only calibration word that is fixed by parameters.

Read data is combinational from the address. A read strobe marks the cycle in which the read is consumed, because reading the status register clears the sticky flag. Writing any value to the current-value register forces the counter to zero and drops the flag, so the next step starts a fresh period.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the control, reload and current-value registers read 0 and the tick interrupt request is low.
- R2: Control register bit 0 enables counting, bit 1 enables the tick request and bit 2 selects the core clock (1) or the reference enable (0). These bits read back as written. Bit 16 is the sticky flag. All other bits read 0.
- R3: With bit 2 set and counting enabled, the counter drops by one on every clock. With counting disabled it holds its value.
- R4: With bit 2 clear, the counter changes only on cycles in which the reference enable input is high.
- R5: A step taken at 1 makes the counter 0 and sets the sticky flag. A step taken at 0 loads the reload value, so a nonzero reload value N gives a period of N+1 steps.
- R6: The sticky flag reads as 1 in control bit 16 after a 1-to-0 step. A read of the control register clears it.
- R7: When control bit 1 is set, each 1-to-0 step raises the tick request for exactly one cycle. When bit 1 is clear, the request stays low.
- R8: A write of any value to the current-value register (offset 0x8) sets the counter to 0 and clears the sticky flag.
- R9: A reload value of 0 keeps the counter at 0 and never sets the flag.
- R10: The calibration register (offset 0xC) reads as follows: bits 23:0 hold the parameter ten-millisecond value, bit 30 the inexact marker and bit 31 the no-reference marker. Writes to it have no effect.
- R11: The reload register keeps 24 bits. Bits 31:24 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | Single-cycle reference clock enable |
| busAddr | input | 4 | Byte offset of the register |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe (consumes a status read) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| tickIrq | output | 1 | Tick interrupt request pulse |

## Verification
The main counting path is exercised with several reload values and run lengths:

- Reload 1, the shortest period, tells a correct wrap from an off-by-one period.
- Runs shorter than one period tell the first reload after a cleared counter from plain decrement.
- Runs spanning several periods show that the wrap repeats and that the flag stays sticky.
- Reload 0 shows that the counter stays idle.

The reference-enable source is driven with sparse pulses, so counting on idle cycles would show. Interrupt pulses are counted over runs of known length, with the tick request on and off.

// File: rtl/sys_tick_pkg.sv
package sys_tick_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_CUR    = 2'd2,
    SEL_CAL    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic step;
    logic clear;
  } cntCmd_t;

  typedef struct packed {
    logic useCore;
    logic tickInt;
    logic enable;
  } ctrlBits_t;
endpackage

// File: rtl/sys_tick_datapath.sv
module sys_tick_datapath
  import sys_tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] curVal,
  output logic             hitZero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic atZero;
  assign atZero  = (curVal == '0);
  assign hitZero = cmd.step && !cmd.clear && (curVal == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curVal <= '0;
    end else if (cmd.clear) begin
      curVal <= '0;
    end else if (cmd.step) begin
      if (atZero) curVal <= reloadVal;
      else        curVal <= curVal - ONE;
    end
  end

  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.step && !cmd.clear) |=> $stable(curVal));
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && !cmd.clear && curVal > ONE) |=> (curVal == $past(curVal) - ONE));
  a_r5_reload: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && !cmd.clear && curVal == '0) |=> (curVal == $past(reloadVal)));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (curVal == '0));
endmodule

// File: rtl/sys_tick_control.sv
module sys_tick_control
  import sys_tick_pkg::*;
#(
  parameter int               CNT_W      = 24,
  parameter int               DATA_W     = 32,
  parameter logic [CNT_W-1:0] CAL_TENMS  = CNT_W'(999_999),
  parameter bit               CAL_SKEW   = 1'b1,
  parameter bit               CAL_NOREF  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [3:0]        busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  curVal,
  input  logic              hitZero,
  output cntCmd_t           cmd,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [DATA_W-1:0] busRdata,
  output logic              tickIrq
);
  localparam int FLAG_POS = 16;
  localparam int PAD_W    = DATA_W - 2 - CNT_W;
  localparam logic [DATA_W-1:0] CAL_WORD =
    {CAL_NOREF, CAL_SKEW, {PAD_W{1'b0}}, CAL_TENMS};

  ctrlBits_t ctrl;
  logic      countFlag;
  regSel_e   sel;
  logic      aligned, wrCtrl, wrReload, wrCur, rdStatus;

  assign sel      = regSel_e'(busAddr[3:2]);
  assign aligned  = (busAddr[1:0] == 2'b00);
  assign wrCtrl   = busWe && aligned && (sel == SEL_CTRL);
  assign wrReload = busWe && aligned && (sel == SEL_RELOAD);
  assign wrCur    = busWe && aligned && (sel == SEL_CUR);
  assign rdStatus = busRe && !busWe && aligned && (sel == SEL_CTRL);

  assign cmd.clear = wrCur;
  assign cmd.step  = ctrl.enable && (ctrl.useCore || refTick);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrl      <= '0;
      reloadVal <= '0;
    end else begin
      if (wrCtrl)   ctrl      <= '{useCore: busWdata[2], tickInt: busWdata[1], enable: busWdata[0]};
      if (wrReload) reloadVal <= busWdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countFlag <= 1'b0;
      tickIrq   <= 1'b0;
    end else begin
      tickIrq <= hitZero && ctrl.tickInt;
      if (wrCur)         countFlag <= 1'b0;
      else if (hitZero)  countFlag <= 1'b1;
      else if (rdStatus) countFlag <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    if (aligned) begin
      unique case (sel)
        SEL_CTRL: begin
          busRdata[2:0]      = {ctrl.useCore, ctrl.tickInt, ctrl.enable};
          busRdata[FLAG_POS] = countFlag;
        end
        SEL_RELOAD: busRdata[CNT_W-1:0] = reloadVal;
        SEL_CUR:    busRdata[CNT_W-1:0] = curVal;
        SEL_CAL:    busRdata = CAL_WORD;
        default:    busRdata = '0;
      endcase
    end
  end

  a_r7_single: assert property (@(posedge clk) disable iff (!rstN)
    tickIrq |=> !tickIrq);
  a_r7_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    tickIrq |-> countFlag);
  a_r7_gated: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.tickInt |=> !tickIrq);
  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    wrCur |=> !countFlag);
  a_r6_read_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !hitZero) |=> !countFlag);
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import sys_tick_pkg::*;
#(
  parameter int               CNT_W     = 24,
  parameter int               DATA_W    = 32,
  parameter logic [CNT_W-1:0] CAL_TENMS = CNT_W'(999_999),
  parameter bit               CAL_SKEW  = 1'b1,
  parameter bit               CAL_NOREF = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [3:0]        busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              tickIrq
);
  cntCmd_t          cmd;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] curVal;
  logic             hitZero;

  sys_tick_control #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .CAL_TENMS(CAL_TENMS),
    .CAL_SKEW(CAL_SKEW), .CAL_NOREF(CAL_NOREF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .refTick(refTick),
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .busWdata(busWdata),
    .curVal(curVal), .hitZero(hitZero),
    .cmd(cmd), .reloadVal(reloadVal), .busRdata(busRdata), .tickIrq(tickIrq)
  );

  sys_tick_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .reloadVal(reloadVal),
    .curVal(curVal), .hitZero(hitZero)
  );
endmodule

// File: tb/sys_tick_timer_tb.sv
`timescale 1ns/1ps
module sys_tick_timer_tb;
  localparam logic [31:0] EXP_CAL = 32'h400F_423F;
  localparam int NVEC = 6;
  // each vector: reload value, idle cycles while enabled
  localparam logic [31:0] VRELOAD [NVEC] = '{32'd5, 32'd5, 32'd1, 32'd0, 32'd100, 32'd3};
  localparam int          VIDLE   [NVEC] = '{2, 7, 4, 3, 49, 10};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickIrq;

  int checks = 0;
  int errors = 0;
  int irqCount = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  sys_tick_timer #(.CAL_TENMS(24'h0F423F), .CAL_SKEW(1'b1), .CAL_NOREF(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .busAddr(busAddr), .busWe(busWe),
    .busRe(busRe), .busWdata(busWdata), .busRdata(busRdata), .tickIrq(tickIrq)
  );

  always @(negedge clk) if (rstN && tickIrq) irqCount++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // called just after a falling edge; consumes one rising edge
  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    busAddr = a; busRe = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  function automatic logic [31:0] expCur(input logic [31:0] r, input int s);
    int p;
    int m;
    if (r == 0) return 32'd0;
    p = int'(r) + 1;
    m = s % p;
    return (m == 0) ? 32'd0 : r - 32'(m - 1);
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, tickIrq}, 32'd0);
    busRead(4'h0, rd); check("R1 ctrl", rd, 32'd0);
    busRead(4'h4, rd); check("R1 reload", rd, 32'd0);
    busRead(4'h8, rd); check("R1 current", rd, 32'd0);

    // R10 calibration word and read-only
    busRead(4'hC, rd); check("R10 cal", rd, EXP_CAL);
    busWrite(4'hC, 32'h1234_5678);
    busRead(4'hC, rd); check("R10 cal write ignored", rd, EXP_CAL);

    // R2 control bits read back, others zero
    busWrite(4'h0, 32'hFFFF_FFFF);
    busRead(4'h0, rd); check("R2 ctrl readback", rd, 32'h0000_0007);
    busWrite(4'h0, 32'h0000_0000);

    // R11 reload width
    busWrite(4'h4, 32'hFFFF_FFFF);
    busRead(4'h4, rd); check("R11 reload width", rd, 32'h00FF_FFFF);

    // table walk: R3, R5, R6, R9 with core clock
    for (int i = 0; i < NVEC; i++) begin
      int steps;
      logic [31:0] r;
      r = VRELOAD[i];
      steps = VIDLE[i] + 1;
      busWrite(4'h0, 32'h0);
      busWrite(4'h4, r);
      busWrite(4'h8, 32'hDEAD);
      busWrite(4'h0, 32'h5);
      repeat (VIDLE[i]) @(negedge clk);
      busWrite(4'h0, 32'h4);
      busRead(4'h8, rd); check("R3/R5/R9 count value", rd, expCur(r, steps));
      busRead(4'h0, rd);
      check("R6/R9 flag after run", rd, 32'h4 | (((r != 0) && (steps >= int'(r) + 1)) ? 32'h1_0000 : 32'h0));
      busRead(4'h0, rd); check("R6 flag cleared by read", rd, 32'h4);
      busRead(4'h8, rd); check("R3 hold while disabled", rd, expCur(r, steps));
    end

    // R4 reference enable source
    busWrite(4'h4, 32'd10);
    busWrite(4'h8, 32'd0);
    busWrite(4'h0, 32'h1);
    for (int k = 0; k < 3; k++) begin
      refTick = 1'b1; @(negedge clk);
      refTick = 1'b0; @(negedge clk); @(negedge clk);
    end
    busWrite(4'h0, 32'h0);
    busRead(4'h8, rd); check("R4 counts only on reference enable", rd, 32'd8);

    // R7 tick request enabled: reload 2, 9 steps -> 3 pulses
    busWrite(4'h4, 32'd2);
    busWrite(4'h8, 32'd0);
    irqCount = 0;
    busWrite(4'h0, 32'h7);
    repeat (8) @(negedge clk);
    busWrite(4'h0, 32'h6);
    @(negedge clk); @(negedge clk);
    check("R7 pulse count with tick request on", irqCount, 32'd3);

    // R7 tick request disabled
    busWrite(4'h8, 32'd0);
    irqCount = 0;
    busWrite(4'h0, 32'h5);
    repeat (8) @(negedge clk);
    busWrite(4'h0, 32'h4);
    @(negedge clk); @(negedge clk);
    check("R7 no pulse with tick request off", irqCount, 32'd0);
    busRead(4'h0, rd); check("R5 flag set by wrap", rd, 32'h1_0004);

    // R8 write to current clears counter and flag
    busWrite(4'h4, 32'd20);
    busWrite(4'h8, 32'd0);
    busWrite(4'h0, 32'h5);
    repeat (24) @(negedge clk);
    busWrite(4'h0, 32'h4);
    busWrite(4'h8, 32'h0000_1234);
    busRead(4'h8, rd); check("R8 counter cleared", rd, 32'd0);
    busRead(4'h0, rd); check("R8 flag cleared", rd, 32'h4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule